// File: doc/BRIEF.md
# Four-Phase Bit Timing Generator

This block derives the bit timing of a character display terminal from one master clock, nominally 2.4576 MHz. Two chained divide-by-two flip-flops, both clocked by the master clock, form a four-state count. The first stage toggles on every clock. Its output leaves the block as a half-rate clock (1.2288 MHz) that drives the vertical character expansion in the deflection circuits. The second stage toggles when the first is set, so the pair steps through four states per bit.

A four-state sequencer runs alongside the dividers. Its states are `PH_OPEN`, `PH_MID_A`, `PH_MID_B` and `PH_CLOSE`, and its transitions are `OPEN->MID_A`, `MID_A->MID_B`, `MID_B->CLOSE` and `CLOSE->OPEN`, one per clock. From the sequencer the block produces four registered, one-clock phase strobes. These strobes carry the phase names 3, 4, 1 and 2 and occur in that order. Together the four clocks make up one bit time:
- Start-of-bit gating uses the opening strobe (phase 3).
- End-of-bit gating uses the closing strobe (phase 2).
- The two middle strobes serve mid-bit gating.

A further two-clock strobe, "phase one-and-two", is taken directly from the set output of the second divider stage. The closing strobe advances a bit counter of parameterised width and modulus. That counter raises a one-clock wrap flag when it returns to zero. A synchronous reset clears both dividers, the sequencer and the counter.

Top module: `bit_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `strobe_open` is 1, the other three phase strobes are 0, and `half_rate_clk`, `strobe_late_half`, `bit_count` and `bit_wrap` are all 0.
- R2: In the first cycle after `rst` is released (cycle 0), `strobe_open` (phase 3) is the active strobe.
- R3: The phase strobes follow the repeating order `strobe_open`, `strobe_mid_a`, `strobe_mid_b`, `strobe_close` (phases 3, 4, 1, 2), one clock each. In cycle k after release, the active phase index is k mod 4, where index 0 is open and index 3 is close.
- R4: Exactly one of the four phase strobes is 1 in every cycle.
- R5: `half_rate_clk` is 0 in phase index 0 and 2 and is 1 in phase index 1 and 3, so it has a period of two master clocks.
- R6: `strobe_late_half` is 1 exactly in phase index 2 and 3 (phases 1 and 2) and is 0 otherwise.
- R7: `bit_count` changes only on the edge that ends `strobe_close`, and it increases by one there. In cycle k it equals floor(k/4) mod `BIT_MOD`.
- R8: After the value `BIT_MOD-1`, `bit_count` wraps to 0. `bit_wrap` is 1 in exactly the cycles where the count has just wrapped to 0, that is at k > 0 with k mod 4 = 0 and floor(k/4) mod `BIT_MOD` = 0.
- R9: Asserting `rst` in any phase returns the block to the R1 state at the next edge. Counting then restarts from cycle 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| half_rate_clk | output | 1 | First divider stage, half the master rate |
| strobe_open | output | 1 | Start-of-bit phase strobe (phase 3) |
| strobe_mid_a | output | 1 | First mid-bit strobe (phase 4) |
| strobe_mid_b | output | 1 | Second mid-bit strobe (phase 1) |
| strobe_close | output | 1 | End-of-bit strobe (phase 2) |
| strobe_late_half | output | 1 | Second divider stage set output (phases 1 and 2) |
| bit_count | output | CNT_W | Bit counter value |
| bit_wrap | output | 1 | One-clock flag on counter wrap to zero |

## Verification
Every output is a flop, so a reset edge takes effect in the very next cycle. The phase strobes, the half-rate clock and the one-and-two strobe then follow the cycle index k directly. The bit count and wrap flag trail the closing strobe by one edge, so they change in the cycle of the next opening strobe. The bench releases reset on a falling edge, numbers that cycle 0, and steps one falling edge at a time. It compares every output against values computed from k alone. Because sampling happens mid-cycle, each result is read in the exact cycle it is due.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        PH_OPEN  = 2'd0,
        PH_MID_A = 2'd1,
        PH_MID_B = 2'd2,
        PH_CLOSE = 2'd3
    } phase_e;

    localparam int unsigned NUM_PHASES = 4;

    localparam int unsigned IDX_OPEN  = 0;
    localparam int unsigned IDX_MID_A = 1;
    localparam int unsigned IDX_MID_B = 2;
    localparam int unsigned IDX_CLOSE = 3;

    typedef logic [NUM_PHASES-1:0] strobe_vec_t;

    function automatic strobe_vec_t phase_onehot(input phase_e ph);
        strobe_vec_t v;
        v = '0;
        v[ph] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bt_divider.sv
module bt_divider (
    input  logic clk,
    input  logic rst,
    output logic half_q,
    output logic quad_q
);

    logic half_d;
    logic quad_d;

    always_comb begin
        half_d = ~half_q;
        quad_d = quad_q ^ half_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            quad_q <= 1'b0;
        end else begin
            half_q <= half_d;
            quad_q <= quad_d;
        end
    end

endmodule

// File: rtl/bt_phase_seq.sv
module bt_phase_seq
    import bt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output strobe_vec_t strobes
);

    phase_e state_q;
    phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OPEN:  state_d = PH_MID_A;
            PH_MID_A: state_d = PH_MID_B;
            PH_MID_B: state_d = PH_CLOSE;
            PH_CLOSE: state_d = PH_OPEN;
            default:  state_d = PH_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobes <= phase_onehot(PH_OPEN);
        end else begin
            strobes <= phase_onehot(state_d);
        end
    end

endmodule

// File: rtl/bt_bit_counter.sv
module bt_bit_counter #(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned BIT_MOD = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(BIT_MOD - 1);
    localparam bit NATURAL_ROLL = (BIT_MOD == (1 << CNT_W));

    logic at_last;
    logic [CNT_W-1:0] count_d;

    assign at_last = (count == LAST_VAL);

    generate
        if (NATURAL_ROLL) begin : g_roll
            always_comb count_d = count + 1'b1;
        end else begin : g_cmp
            always_comb count_d = at_last ? '0 : count + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            wrap  <= 1'b0;
        end else begin
            wrap <= step && at_last;
            if (step) begin
                count <= count_d;
            end
        end
    end

endmodule

// File: rtl/bit_timing_gen.sv
module bit_timing_gen
    import bt_pkg::*;
#(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned BIT_MOD = 10
) (
    input  logic             clk,
    input  logic             rst,
    output logic             half_rate_clk,
    output logic             strobe_open,
    output logic             strobe_mid_a,
    output logic             strobe_mid_b,
    output logic             strobe_close,
    output logic             strobe_late_half,
    output logic [CNT_W-1:0] bit_count,
    output logic             bit_wrap
);

    logic        half_q;
    logic        quad_q;
    strobe_vec_t strobes;

    bt_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .half_q (half_q),
        .quad_q (quad_q)
    );

    bt_phase_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .strobes (strobes)
    );

    bt_bit_counter #(
        .CNT_W   (CNT_W),
        .BIT_MOD (BIT_MOD)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (strobes[IDX_CLOSE]),
        .count (bit_count),
        .wrap  (bit_wrap)
    );

    assign half_rate_clk    = half_q;
    assign strobe_late_half = quad_q;
    assign strobe_open      = strobes[IDX_OPEN];
    assign strobe_mid_a     = strobes[IDX_MID_A];
    assign strobe_mid_b     = strobes[IDX_MID_B];
    assign strobe_close     = strobes[IDX_CLOSE];

endmodule

// File: rtl/bt_timing_checker.sv
module bt_timing_checker #(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned BIT_MOD = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             half_rate_clk,
    input logic             strobe_open,
    input logic             strobe_mid_a,
    input logic             strobe_mid_b,
    input logic             strobe_close,
    input logic             strobe_late_half,
    input logic [CNT_W-1:0] bit_count,
    input logic             bit_wrap
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (strobe_open && !strobe_close && !half_rate_clk && bit_count == '0));

    p_order_open_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_open |=> strobe_mid_a);
    p_order_mid_a_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_mid_a |=> strobe_mid_b);
    p_order_mid_b_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_mid_b |=> strobe_close);
    p_order_close_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_close |=> strobe_open);

    p_one_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({strobe_open, strobe_mid_a, strobe_mid_b, strobe_close}) == 1);

    p_half_phase_r5: assert property (@(posedge clk) disable iff (rst)
        half_rate_clk == (strobe_mid_a || strobe_close));

    p_late_half_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_late_half == (strobe_mid_b || strobe_close));

    p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !strobe_close |=> $stable(bit_count));

    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        bit_wrap |-> (bit_count == '0 && strobe_open));

endmodule

bind bit_timing_gen bt_timing_checker #(.CNT_W(CNT_W), .BIT_MOD(BIT_MOD)) u_chk (.*);

// File: tb/bit_timing_gen_test.sv
`timescale 1ns/1ps
module bit_timing_gen_test;

    localparam int unsigned CNT_W   = 4;
    localparam int unsigned BIT_MOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             half_rate_clk;
    logic             strobe_open;
    logic             strobe_mid_a;
    logic             strobe_mid_b;
    logic             strobe_close;
    logic             strobe_late_half;
    logic [CNT_W-1:0] bit_count;
    logic             bit_wrap;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #2.5 clk = ~clk;

    bit_timing_gen #(.CNT_W(CNT_W), .BIT_MOD(BIT_MOD)) uut (
        .clk              (clk),
        .rst              (rst),
        .half_rate_clk    (half_rate_clk),
        .strobe_open      (strobe_open),
        .strobe_mid_a     (strobe_mid_a),
        .strobe_mid_b     (strobe_mid_b),
        .strobe_close     (strobe_close),
        .strobe_late_half (strobe_late_half),
        .bit_count        (bit_count),
        .bit_wrap         (bit_wrap)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", req, k, actual, expected);
        end
    endtask

    function automatic int exp_strobes(input int kk);
        return 1 << (kk % 4);
    endfunction

    function automatic int act_strobes();
        return {strobe_close, strobe_mid_b, strobe_mid_a, strobe_open};
    endfunction

    task automatic step();
        @(negedge clk);
        k++;
    endtask

    task automatic do_reset_release();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0;
        #0.5;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 strobes", act_strobes(), 1);
        check("R1 half_rate_clk", int'(half_rate_clk), 0);
        check("R1 late_half", int'(strobe_late_half), 0);
        check("R1 bit_count", int'(bit_count), 0);
        check("R1 bit_wrap", int'(bit_wrap), 0);
        rst = 1'b0;
        k = 0;
        #0.5;
        check("R2 first cycle open", act_strobes(), 1);
    endtask

    task automatic t_phase_order();
        do_reset_release();
        for (int i = 0; i < 16; i++) begin
            step();
            check("R3 phase order", act_strobes(), exp_strobes(k));
            check("R4 one strobe", $countones(act_strobes()), 1);
        end
    endtask

    task automatic t_half_and_late();
        do_reset_release();
        for (int i = 0; i < 12; i++) begin
            check("R5 half_rate_clk", int'(half_rate_clk), k % 2);
            check("R6 late_half", int'(strobe_late_half), int'((k % 4) >= 2));
            step();
        end
    endtask

    task automatic t_count_wraps();
        do_reset_release();
        for (int i = 0; i < 4 * BIT_MOD * 3 + 6; i++) begin
            check("R7 bit_count", int'(bit_count), (k / 4) % BIT_MOD);
            check("R8 bit_wrap", int'(bit_wrap),
                  int'(k > 0 && (k % 4) == 0 && ((k / 4) % BIT_MOD) == 0));
            step();
        end
    endtask

    task automatic t_midrun_reset();
        do_reset_release();
        for (int i = 0; i < 4 * 3 + 2; i++) step();
        check("R9 pre-reset in mid_b", act_strobes(), 4);
        rst = 1'b1;
        @(negedge clk);
        check("R9 strobes after reset", act_strobes(), 1);
        check("R9 count after reset", int'(bit_count), 0);
        check("R9 half after reset", int'(half_rate_clk), 0);
        rst = 1'b0;
        k = 0;
        for (int i = 0; i < 8; i++) begin
            check("R9 restart order", act_strobes(), exp_strobes(k));
            check("R9 restart count", int'(bit_count), k / 4);
            step();
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_phase_order();
        t_half_and_late();
        t_count_wraps();
        t_midrun_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule